// File: doc/BRIEF.md
# Floating-Point Exception Status Update Unit

This block keeps a floating-point status register and applies the result of each finished FP operation to it. A 5-bit vector of raised IEEE exceptions comes in with an update strobe. The block compares that vector against the trap-enable mask held in the register. It then rewrites the current-exception and accrued-exception fields and the trap-type field.

The outcome of each update is one of two cases. If any raised exception is enabled, the block requests a trap. In that case only the single highest-priority enabled exception is recorded. If none is enabled, the operation retires: every raised flag is recorded and accumulated, and a small program-counter pair steps forward. Software state reaches the register through a plain load port. An update in the same cycle as a load takes precedence over it.

Top module: `fpx_status_update`

## Requirements
- R1: After reset the status register equals `RESET_SR`, `trap_req` and `retire` are low, `pc` equals `RESET_PC` and `npc` equals `RESET_NPC`.
- R2: With `upd_en` low and `ld_en` high, the status register takes `ld_data` on the next clock edge. With both low it holds, and neither pulse is asserted.
- R3: The exception encoding, in both the raised vector and every status field, is: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. An update traps exactly when `raised` ANDed with the trap-enable mask (status bits 27:23) is nonzero. `trap_req` is then high for one cycle: the cycle in which the updated status is first visible.
- R4: On a trapping update, the current-exception field (status bits 4:0) becomes one-hot. It holds the highest-priority bit of `raised & mask`, in the order invalid, overflow, underflow, divide-by-zero, inexact.
- R5: On a non-trapping update, the current-exception field is replaced by the full `raised` vector.
- R6: The accrued-exception field (status bits 9:5) is ORed with `raised` on a non-trapping update. It is left unchanged on a trapping update.
- R7: The trap-type field (status bits 16:14) becomes 1 on a trapping update and 0 on a non-trapping update.
- R8: A non-trapping update pulses `retire` for one cycle, in the same cycle as the status change. On that edge `pc` takes the old `npc` and `npc` advances by `PC_STEP`, modulo 2^`PC_W`. A trapping update leaves `pc` and `npc` unchanged.
- R9: An update with `raised` equal to zero clears the current-exception field, leaves the accrued field unchanged and retires.
- R10: An update changes no status bits outside fields 4:0, 9:5 and 16:14. A load presented in the same cycle as an update is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load the status register from `ld_data` |
| ld_data | input | SR_W | Value to load |
| upd_en | input | 1 | Apply `raised` as the result of a finished operation |
| raised | input | 5 | Exceptions raised by the operation |
| status | output | SR_W | Current status register |
| trap_req | output | 1 | One-cycle trap request |
| retire | output | 1 | One-cycle retire pulse |
| pc | output | PC_W | Current program counter |
| npc | output | PC_W | Next program counter |

## Verification
The bench builds the block with `PC_W` = 8, `RESET_PC` = 0xF0 and `RESET_NPC` = 0xF4. Because of these values, the next-PC wraps through zero after only a few retires, so the modular step of R8 is exercised. The bench also sets `RESET_SR` to a nonzero pattern outside the exception fields, which shows that reset loads that value and that updates preserve the bits R10 protects. For every one of the 32 raised vectors with all traps enabled, and under partial masks, the bench checks the status fields against its own priority model.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXC_W   = 5;
  localparam int CEXC_LO = 0;
  localparam int AEXC_LO = 5;
  localparam int TT_LO   = 14;
  localparam int TT_W    = 3;
  localparam int TEM_LO  = 23;
  localparam logic [TT_W-1:0] TT_IEEE = 3'd1;
  localparam logic [TT_W-1:0] TT_NONE = 3'd0;

  typedef struct packed {
    logic             trap;
    logic [EXC_W-1:0] cexc;
  } exc_dec_t;

  // keep only the most severe flag, invalid first, inexact last
  function automatic logic [EXC_W-1:0] keep_top(input logic [EXC_W-1:0] v);
    logic [EXC_W-1:0] r;
    r = '0;
    for (int i = 0; i < EXC_W; i++)
      if (v[i]) r = EXC_W'(1) << i;
    return r;
  endfunction

  function automatic exc_dec_t decide(input logic [EXC_W-1:0] raised,
                                      input logic [EXC_W-1:0] mask);
    exc_dec_t d;
    d.trap = |(raised & mask);
    d.cexc = d.trap ? keep_top(raised & mask) : raised;
    return d;
  endfunction
endpackage

// File: rtl/fpx_trap_sel.sv
module fpx_trap_sel
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXC_W-1:0] raised,
  input  logic [EXC_W-1:0] mask,
  output exc_dec_t         dec
);
  always_comb dec = decide(raised, mask);

  AST_SEL_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dec.trap |-> ((dec.cexc & ~mask) == '0));  // R4
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dec.trap |-> $onehot(dec.cexc));  // R4
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
#(
  parameter int unsigned       SR_W     = 32,
  parameter logic [SR_W-1:0]   RESET_SR = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SR_W-1:0]  ld_data,
  input  logic             upd_en,
  input  logic [EXC_W-1:0] raised,
  input  exc_dec_t         dec,
  output logic [SR_W-1:0]  sr,
  output logic             trap_q,
  output logic             retire_q
);
  logic [SR_W-1:0] sr_nxt;
  logic            upd_trap;
  logic            upd_ok;

  assign upd_trap = upd_en &&  dec.trap;
  assign upd_ok   = upd_en && !dec.trap;

  always_comb begin
    sr_nxt = sr;
    if (upd_en) begin
      sr_nxt[CEXC_LO +: EXC_W] = dec.cexc;
      if (!dec.trap)
        sr_nxt[AEXC_LO +: EXC_W] = sr[AEXC_LO +: EXC_W] | raised;
      sr_nxt[TT_LO +: TT_W] = dec.trap ? TT_IEEE : TT_NONE;
    end else if (ld_en) begin
      sr_nxt = ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= RESET_SR;
      trap_q   <= 1'b0;
      retire_q <= 1'b0;
    end else begin
      sr       <= sr_nxt;
      trap_q   <= upd_trap;
      retire_q <= upd_ok;
    end
  end

  AST_TRAP_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_q || retire_q) |-> $past(upd_en));  // R3
  AST_TRAP_RETIRE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_q && retire_q));  // R8
  AST_CEXC_ONEHOT_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> $onehot(sr[CEXC_LO +: EXC_W]));  // R4
  AST_AEXC_HELD_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> (sr[AEXC_LO +: EXC_W] == $past(sr[AEXC_LO +: EXC_W])));  // R6
  AST_AEXC_ACCUM_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    retire_q |-> (sr[AEXC_LO +: EXC_W] ==
                  ($past(sr[AEXC_LO +: EXC_W]) | sr[CEXC_LO +: EXC_W])));  // R6
  AST_TT_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> (sr[TT_LO +: TT_W] == TT_IEEE));  // R7
  AST_TT_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    retire_q |-> (sr[TT_LO +: TT_W] == TT_NONE));  // R7
  AST_TEM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_q || retire_q) |-> $stable(sr[SR_W-1:TEM_LO]));  // R10
endmodule

// File: rtl/fpx_pc_step.sv
module fpx_pc_step #(
  parameter int unsigned     PC_W      = 32,
  parameter int unsigned     PC_STEP   = 4,
  parameter logic [PC_W-1:0] RESET_PC  = '0,
  parameter logic [PC_W-1:0] RESET_NPC = PC_W'(4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] npc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= RESET_PC;
      npc <= RESET_NPC;
    end else if (advance) begin
      pc  <= npc;
      npc <= npc + STEP;
    end
  end

  AST_PC_FOLLOWS_NPC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(advance) |-> (pc == $past(npc)));  // R8
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(advance) |-> ($stable(pc) && $stable(npc)));  // R8
endmodule

// File: rtl/fpx_status_update.sv
module fpx_status_update
  import fpx_pkg::*;
#(
  parameter int unsigned     SR_W      = 32,
  parameter int unsigned     PC_W      = 32,
  parameter int unsigned     PC_STEP   = 4,
  parameter logic [SR_W-1:0] RESET_SR  = '0,
  parameter logic [PC_W-1:0] RESET_PC  = '0,
  parameter logic [PC_W-1:0] RESET_NPC = PC_W'(4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [SR_W-1:0] ld_data,
  input  logic            upd_en,
  input  logic [4:0]      raised,
  output logic [SR_W-1:0] status,
  output logic            trap_req,
  output logic            retire,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] npc
);
  exc_dec_t         dec_w;
  logic [EXC_W-1:0] tem_w;
  logic             advance_w;

  assign tem_w     = status[TEM_LO +: EXC_W];
  assign advance_w = upd_en && !dec_w.trap;

  fpx_trap_sel u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .raised (raised),
    .mask   (tem_w),
    .dec    (dec_w)
  );

  fpx_status_reg #(
    .SR_W     (SR_W),
    .RESET_SR (RESET_SR)
  ) u_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_data  (ld_data),
    .upd_en   (upd_en),
    .raised   (raised),
    .dec      (dec_w),
    .sr       (status),
    .trap_q   (trap_req),
    .retire_q (retire)
  );

  fpx_pc_step #(
    .PC_W      (PC_W),
    .PC_STEP   (PC_STEP),
    .RESET_PC  (RESET_PC),
    .RESET_NPC (RESET_NPC)
  ) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance_w),
    .pc      (pc),
    .npc     (npc)
  );

  AST_RETIRE_MOVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (pc == $past(npc)));  // R8
  AST_TRAP_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $stable(pc));  // R8
endmodule

// File: tb/test_fpx_status_update.sv
module test_fpx_status_update;
  localparam int unsigned SR_W = 32;
  localparam int unsigned PC_W = 8;
  localparam logic [SR_W-1:0] RST_SR = 32'hA000_0000;
  localparam logic [PC_W-1:0] RST_PC = 8'hF0;
  localparam logic [PC_W-1:0] RST_NPC = 8'hF4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [SR_W-1:0] ld_data = '0;
  logic upd_en = 1'b0;
  logic [4:0] raised = '0;
  logic [SR_W-1:0] status;
  logic trap_req, retire;
  logic [PC_W-1:0] pc, npc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [SR_W-1:0] m_sr;
  logic [PC_W-1:0] m_pc, m_npc;
  logic m_trap, m_ret;

  always #5 clk = ~clk;

  fpx_status_update #(
    .SR_W(SR_W), .PC_W(PC_W), .PC_STEP(4),
    .RESET_SR(RST_SR), .RESET_PC(RST_PC), .RESET_NPC(RST_NPC)
  ) i_fpx_status_update (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
    .upd_en(upd_en), .raised(raised), .status(status),
    .trap_req(trap_req), .retire(retire), .pc(pc), .npc(npc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " status"}, 64'(status), 64'(m_sr));
    chk({req, " trap_req"}, 64'(trap_req), 64'(m_trap));
    chk({req, " retire"}, 64'(retire), 64'(m_ret));
    chk({req, " pc"}, 64'(pc), 64'(m_pc));
    chk({req, " npc"}, 64'(npc), 64'(m_npc));
  endtask

  // model: scan from the most severe flag downwards
  task automatic model_update(input logic [4:0] r);
    logic [4:0] en, pick;
    en = r & m_sr[27:23];
    pick = '0;
    for (int k = 4; k >= 0; k--)
      if (en[k] && pick == '0) pick[k] = 1'b1;
    if (en != 0) begin
      m_sr[4:0] = pick;
      m_sr[16:14] = 3'b001;
      m_trap = 1; m_ret = 0;
    end else begin
      m_sr[4:0] = r;
      m_sr[9:5] = m_sr[9:5] | r;
      m_sr[16:14] = 3'b000;
      m_trap = 0; m_ret = 1;
      m_pc = m_npc;
      m_npc = m_npc + 8'd4;
    end
  endtask

  task automatic do_load(input logic [SR_W-1:0] v);
    @(negedge clk); ld_en = 1; ld_data = v;
    @(negedge clk); ld_en = 0;
    m_sr = v; m_trap = 0; m_ret = 0;
  endtask

  task automatic do_upd(input logic [4:0] r, input string req);
    @(negedge clk); upd_en = 1; raised = r;
    @(negedge clk); upd_en = 0; raised = '0;
    model_update(r);
    chk_all(req);
    m_trap = 0; m_ret = 0;
  endtask

  task automatic t_reset;
    m_sr = RST_SR; m_pc = RST_PC; m_npc = RST_NPC; m_trap = 0; m_ret = 0;
    chk_all("R1 reset");
  endtask

  task automatic t_load_idle;
    do_load(32'h0000_0000 | (32'h12 << 23) | 32'h0000_3C00);
    chk_all("R2 load");
    @(negedge clk); @(negedge clk);
    chk_all("R2 idle hold");
  endtask

  task automatic t_no_trap;
    do_load(32'h0000_0000 | (32'b00010 << 23));
    do_upd(5'b10101, "R5 full vector no trap");
    chk("R6 aexc accumulated", 64'(status[9:5]), 64'h15);
    do_upd(5'b01000, "R6 aexc OR");
    chk("R6 aexc second", 64'(status[9:5]), 64'h1D);
  endtask

  task automatic t_trap_single;
    do_upd(5'b00011, "R3 trap on enabled divzero");
    chk("R7 tt ieee", 64'(status[16:14]), 64'h1);
    chk("R4 cexc divzero", 64'(status[4:0]), 64'h2);
    chk("R6 aexc held", 64'(status[9:5]), 64'h1D);
  endtask

  task automatic t_priority_all;
    for (int v = 0; v < 32; v++) begin
      do_load(32'h5000_0000 | (32'h1F << 23));
      do_upd(5'(v), "R4 priority sweep");
    end
  endtask

  task automatic t_partial_mask;
    do_load(32'h0000_0000 | (32'b00101 << 23) | (32'h3 << 5));
    do_upd(5'b11111, "R4 partial mask picks underflow");
    chk("R4 underflow bit", 64'(status[4:0]), 64'h4);
    do_upd(5'b11010, "R3 disabled flags do not trap");
    chk("R7 tt cleared", 64'(status[16:14]), 64'h0);
  endtask

  task automatic t_zero;
    do_load(32'h0000_0000 | (32'h1F << 23) | (32'h0A << 5) | 32'h11);
    do_upd(5'b00000, "R9 zero vector retires");
    chk("R9 cexc cleared", 64'(status[4:0]), 64'h0);
    chk("R9 aexc kept", 64'(status[9:5]), 64'h0A);
  endtask

  task automatic t_collision;
    do_load(32'h0000_0000 | (32'h01 << 23) | 32'h0040_0000);
    @(negedge clk); upd_en = 1; raised = 5'b00100; ld_en = 1; ld_data = 32'hFFFF_FFFF;
    @(negedge clk); upd_en = 0; raised = '0; ld_en = 0;
    model_update(5'b00100);
    chk_all("R10 load ignored during update");
    chk("R10 other bits kept", 64'(status[22]), 64'h1);
    m_trap = 0; m_ret = 0;
  endtask

  task automatic t_wrap;
    do_load('0);
    for (int k = 0; k < 6; k++) do_upd(5'b00001, "R8 pc step with wrap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load_idle();
    t_no_trap();
    t_trap_single();
    t_priority_all();
    t_partial_mask();
    t_zero();
    t_collision();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule